// File: doc/BRIEF.md
# DRAM Write Command Sequencer

This block turns host write requests into a timed stream of DRAM commands. Each request names a bank, a row, a starting column and a burst length. The block looks up its per-bank record of open rows and classifies the request as one of three cases:

- **hit**: the bank is open on the same row.
- **miss**: the bank is open on another row.
- **empty**: the bank is closed.

It then drives the precharge, activate and column-write commands that the case needs, one per cycle, on a single command output.

The minimum spacings between commands are run-time inputs counted in clock cycles:

| Input | Spacing it sets |
|-------|-----------------|
| `t_rp` | precharge to activate |
| `t_rcd` | activate to write |
| `t_cc` | write to write |
| `t_wrp` | write to precharge |
| `t_ras` | activate to precharge |

The block places every command in the first cycle that all of these limits permit. A strobe marks the launch of each write's data packet a programmable number of cycles after the write. A per-request policy bit chooses whether the bank is closed by a precharge once the burst has finished, or is left open for later hits.

Top module: `dram_wr_sequencer`

## Requirements
- R1: After reset, `cmd_op` is NOP, `req_ready` is high and `wdata_launch` is low. Every bank is marked closed, so the first request to any bank starts with an activate.
- R2: A request whose bank is open on the requested row issues only column writes, with no precharge and no activate.
- R3: A request whose bank is open on another row first precharges that bank. The precharge comes no sooner than `t_ras` after that bank's last activate and no sooner than `t_wrp` after that bank's last write. The activate to the new row follows no sooner than `t_rp` after the precharge.
- R4: A request to a closed bank first activates the requested row. The first write follows no sooner than `t_rcd` after the most recent activate.
- R5: A request carrying `req_len` = n issues n+1 writes to consecutive columns, starting at `req_col` and wrapping modulo 2^COL_W. Each write comes no sooner than `t_cc` after the previous write, including a write from an earlier request.
- R6: `wdata_launch` is a one-cycle pulse exactly `t_cwd` cycles after each write command, in the same cycle when `t_cwd` is 0.
- R7: `close_page` is sampled when a request is accepted. If it is 1, the bank is precharged after the last write, no sooner than `t_wrp` after that write and no sooner than `t_ras` after the bank's activate, whichever is later. If it is 0, the bank stays open on that row.
- R8: At most one command is driven per cycle on `cmd_op`, encoded as 0 = NOP, 1 = precharge, 2 = activate, 3 = write. Precharge carries `cmd_bank`; activate carries `cmd_bank` and `cmd_row`; write carries `cmd_bank` and `cmd_col`. All unused fields, and every field during NOP, are zero.
- R9: `req_ready` is high only while idle, and a request is taken on a cycle with `req_valid` and `req_ready` both high. `req_ready` stays low from acceptance until the request's final command (its last write, or its closing precharge) is driven, and is high in that cycle.
- R10: The first command of a request appears no earlier than the cycle after acceptance. Every command appears in the first cycle that all the limits above permit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_bank | input | BA_W | Target bank |
| req_row | input | ROW_W | Target row |
| req_col | input | COL_W | First column of the burst |
| req_len | input | LEN_W | Number of column writes minus one |
| close_page | input | 1 | 1: precharge the bank after the burst |
| t_rp | input | TW | Precharge-to-activate cycles |
| t_rcd | input | TW | Activate-to-write cycles |
| t_cc | input | TW | Write-to-write cycles |
| t_wrp | input | TW | Write-to-precharge cycles |
| t_ras | input | TW | Activate-to-precharge cycles |
| t_cwd | input | TW | Write-to-data-launch cycles |
| cmd_op | output | 2 | Command code (0 NOP, 1 PRE, 2 ACT, 3 WR) |
| cmd_bank | output | BA_W | Command bank |
| cmd_row | output | ROW_W | Row for activate |
| cmd_col | output | COL_W | Column for write |
| wdata_launch | output | 1 | Write data packet launch strobe |

## Verification
The gap assertions assume the timing inputs hold steady while commands are in flight. A counter loaded with an older value would otherwise space commands by a different amount than the one compared. The bench changes timing only after the sequencer has sat idle longer than any gap.

The assertions also take `t_rp`, `t_rcd`, `t_cc` and `t_ras` as at least 1. In their checks, a value of 0 behaves as 1, because only one command fits in a cycle; every configuration the bench uses keeps these at 1 or more.

Request fields are sampled only at acceptance. The bench therefore changes them freely between requests, with bank, row and length drawn from small ranges so that hits, misses and empties all occur.

// File: rtl/wseq_pkg.sv
package wseq_pkg;

    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_PRE = 2'd1,
        OP_ACT = 2'd2,
        OP_WR  = 2'd3
    } wseq_op_e;

    typedef enum logic [1:0] {
        PG_HIT,
        PG_MISS,
        PG_EMPTY
    } wseq_page_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_WR,
        ST_CLOSE
    } wseq_state_e;

    function automatic wseq_page_e page_class(input logic is_open, input logic same_row);
        if (!is_open)      return PG_EMPTY;
        else if (same_row) return PG_HIT;
        else               return PG_MISS;
    endfunction

    function automatic wseq_state_e first_state(input wseq_page_e pg);
        case (pg)
            PG_HIT:  return ST_WR;
            PG_MISS: return ST_PRE;
            default: return ST_ACT;
        endcase
    endfunction

endpackage

// File: rtl/wseq_gap_timer.sv
module wseq_gap_timer #(
    parameter int TW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          ok
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= value;
        else if (cnt != '0)  cnt <= cnt - TW'(1);
    end

    // A command may be registered while the count is 1 or less: it becomes
    // visible on the following edge, exactly value cycles after the load.
    assign ok = (cnt <= TW'(1));
endmodule

// File: rtl/wseq_bank_table.sv
module wseq_bank_table #(
    parameter int BANKS = 8,
    parameter int ROW_W = 14,
    parameter int TW    = 6,
    localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BA_W-1:0]  upd_bank,
    input  logic             act_en,
    input  logic             pre_en,
    input  logic             wr_en,
    input  logic [ROW_W-1:0] act_row,
    input  logic [TW-1:0]    t_ras,
    input  logic [TW-1:0]    t_wrp,
    input  logic [BA_W-1:0]  q_bank,
    output logic             q_open,
    output logic [ROW_W-1:0] q_row,
    output logic             q_pre_ok
);
    logic [BANKS-1:0] open_r;
    logic [ROW_W-1:0] row_r [BANKS];
    logic [BANKS-1:0] ras_ok;
    logic [BANKS-1:0] wrp_ok;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic hit_b;
        assign hit_b = (upd_bank == BA_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r[b] <= 1'b0;
                row_r[b]  <= '0;
            end else if (act_en && hit_b) begin
                open_r[b] <= 1'b1;
                row_r[b]  <= act_row;
            end else if (pre_en && hit_b) begin
                open_r[b] <= 1'b0;
            end
        end

        wseq_gap_timer #(.TW(TW)) i_ras (
            .clk(clk), .rst(rst), .load(act_en && hit_b), .value(t_ras), .ok(ras_ok[b])
        );
        wseq_gap_timer #(.TW(TW)) i_wrp (
            .clk(clk), .rst(rst), .load(wr_en && hit_b), .value(t_wrp), .ok(wrp_ok[b])
        );
    end

    assign q_open   = open_r[q_bank];
    assign q_row    = row_r[q_bank];
    assign q_pre_ok = ras_ok[q_bank] && wrp_ok[q_bank];
endmodule

// File: rtl/wseq_launch_delay.sv
module wseq_launch_delay #(
    parameter int TW = 6,
    localparam int DEPTH = 2 ** TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_in,
    input  logic [TW-1:0] t_cwd,
    output logic          launch
);
    logic [DEPTH-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[DEPTH-2:0], wr_in};
    end

    assign launch = (t_cwd == '0) ? wr_in : sh[t_cwd - TW'(1)];
endmodule

// File: rtl/dram_wr_sequencer.sv
module dram_wr_sequencer
    import wseq_pkg::*;
#(
    parameter int BANKS = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 7,
    parameter int LEN_W = 4,
    parameter int TW    = 6,
    localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [BA_W-1:0]  req_bank,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic             close_page,
    input  logic [TW-1:0]    t_rp,
    input  logic [TW-1:0]    t_rcd,
    input  logic [TW-1:0]    t_cc,
    input  logic [TW-1:0]    t_wrp,
    input  logic [TW-1:0]    t_ras,
    input  logic [TW-1:0]    t_cwd,
    output logic [1:0]       cmd_op,
    output logic [BA_W-1:0]  cmd_bank,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic             wdata_launch
);
    wseq_state_e      state;
    logic [BA_W-1:0]  cur_bank;
    logic [ROW_W-1:0] cur_row;
    logic [COL_W-1:0] cur_col;
    logic [LEN_W-1:0] left;
    logic             close_q;

    logic             accept;
    logic [BA_W-1:0]  q_bank;
    logic             q_open;
    logic [ROW_W-1:0] q_row;
    logic             q_pre_ok;
    wseq_page_e       page;
    logic             iss_pre, iss_act, iss_wr;
    logic             rp_ok, rcd_ok, cc_ok;
    wseq_op_e         op_q;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign q_bank    = req_ready ? req_bank : cur_bank;
    assign page      = page_class(q_open, q_row == req_row);

    assign iss_pre = ((state == ST_PRE) || (state == ST_CLOSE)) && q_pre_ok;
    assign iss_act = (state == ST_ACT) && rp_ok;
    assign iss_wr  = (state == ST_WR) && rcd_ok && cc_ok;

    wseq_bank_table #(.BANKS(BANKS), .ROW_W(ROW_W), .TW(TW)) i_table (
        .clk(clk), .rst(rst), .upd_bank(cur_bank),
        .act_en(iss_act), .pre_en(iss_pre), .wr_en(iss_wr),
        .act_row(cur_row), .t_ras(t_ras), .t_wrp(t_wrp),
        .q_bank(q_bank), .q_open(q_open), .q_row(q_row), .q_pre_ok(q_pre_ok)
    );

    wseq_gap_timer #(.TW(TW)) i_rp  (.clk(clk), .rst(rst), .load(iss_pre), .value(t_rp),  .ok(rp_ok));
    wseq_gap_timer #(.TW(TW)) i_rcd (.clk(clk), .rst(rst), .load(iss_act), .value(t_rcd), .ok(rcd_ok));
    wseq_gap_timer #(.TW(TW)) i_cc  (.clk(clk), .rst(rst), .load(iss_wr),  .value(t_cc),  .ok(cc_ok));

    // Sequencing state
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_bank <= '0;
            cur_row  <= '0;
            cur_col  <= '0;
            left     <= '0;
            close_q  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    cur_bank <= req_bank;
                    cur_row  <= req_row;
                    cur_col  <= req_col;
                    left     <= req_len;
                    close_q  <= close_page;
                    state    <= first_state(page);
                end
                ST_PRE:   if (iss_pre) state <= ST_ACT;
                ST_ACT:   if (iss_act) state <= ST_WR;
                ST_WR: if (iss_wr) begin
                    cur_col <= cur_col + COL_W'(1);
                    if (left == '0) state <= close_q ? ST_CLOSE : ST_IDLE;
                    else            left  <= left - LEN_W'(1);
                end
                ST_CLOSE: if (iss_pre) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Registered command output
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
        end else begin
            op_q     <= OP_NOP;
            cmd_bank <= '0;
            cmd_row  <= '0;
            cmd_col  <= '0;
            if (iss_pre) begin
                op_q     <= OP_PRE;
                cmd_bank <= cur_bank;
            end else if (iss_act) begin
                op_q     <= OP_ACT;
                cmd_bank <= cur_bank;
                cmd_row  <= cur_row;
            end else if (iss_wr) begin
                op_q     <= OP_WR;
                cmd_bank <= cur_bank;
                cmd_col  <= cur_col;
            end
        end
    end

    assign cmd_op = op_q;

    wseq_launch_delay #(.TW(TW)) i_launch (
        .clk(clk), .rst(rst), .wr_in(op_q == OP_WR), .t_cwd(t_cwd), .launch(wdata_launch)
    );
endmodule

// File: rtl/dram_wr_sequencer_chk.sv
module dram_wr_sequencer_chk #(
    parameter int BANKS = 8,
    parameter int ROW_W = 14,
    parameter int COL_W = 7,
    parameter int TW    = 6,
    localparam int BA_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [TW-1:0]    t_rp,
    input logic [TW-1:0]    t_rcd,
    input logic [TW-1:0]    t_cc,
    input logic [TW-1:0]    t_ras,
    input logic [1:0]       cmd_op,
    input logic [BA_W-1:0]  cmd_bank,
    input logic [ROW_W-1:0] cmd_row,
    input logic [COL_W-1:0] cmd_col
);
    // Cycles since the last command of each kind, saturating; 255 stands for "long ago".
    logic [7:0] since_pre, since_act, since_wr;
    logic [7:0] since_act_b [BANKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            since_pre <= 8'hFF;
            since_act <= 8'hFF;
            since_wr  <= 8'hFF;
            for (int b = 0; b < BANKS; b++) since_act_b[b] <= 8'hFF;
        end else begin
            since_pre <= (cmd_op == 2'd1) ? 8'd1 : ((since_pre == 8'hFF) ? since_pre : since_pre + 8'd1);
            since_act <= (cmd_op == 2'd2) ? 8'd1 : ((since_act == 8'hFF) ? since_act : since_act + 8'd1);
            since_wr  <= (cmd_op == 2'd3) ? 8'd1 : ((since_wr  == 8'hFF) ? since_wr  : since_wr  + 8'd1);
            for (int b = 0; b < BANKS; b++) begin
                if (cmd_op == 2'd2 && cmd_bank == BA_W'(b)) since_act_b[b] <= 8'd1;
                else if (since_act_b[b] != 8'hFF)           since_act_b[b] <= since_act_b[b] + 8'd1;
            end
        end
    end

    assert_nop_fields_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd0) |-> (cmd_bank == '0 && cmd_row == '0 && cmd_col == '0));

    assert_ready_drop_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_rp_gap_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd2) |-> (int'(since_pre) >= int'(t_rp)));

    assert_rcd_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd3) |-> (int'(since_act) >= int'(t_rcd)));

    assert_cc_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd3) |-> (int'(since_wr) >= int'(t_cc)));

    assert_ras_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 2'd1) |-> (int'(since_act_b[cmd_bank]) >= int'(t_ras)));
endmodule

bind dram_wr_sequencer dram_wr_sequencer_chk #(
    .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)
) i_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .t_rp(t_rp), .t_rcd(t_rcd), .t_cc(t_cc), .t_ras(t_ras),
    .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row), .cmd_col(cmd_col)
);

// File: tb/test_dram_wr_sequencer.sv
module test_dram_wr_sequencer;
    localparam int BANKS = 8;
    localparam int ROW_W = 14;
    localparam int COL_W = 7;
    localparam int LEN_W = 4;
    localparam int TW    = 6;
    localparam int BA_W  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [BA_W-1:0]  req_bank = '0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic close_page = 1'b0;
    logic [TW-1:0] t_rp, t_rcd, t_cc, t_wrp, t_ras, t_cwd;
    logic [1:0]       cmd_op;
    logic [BA_W-1:0]  cmd_bank;
    logic [ROW_W-1:0] cmd_row;
    logic [COL_W-1:0] cmd_col;
    logic wdata_launch;

    always #5 clk = ~clk;

    dram_wr_sequencer #(.BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .LEN_W(LEN_W), .TW(TW)) i_dram_wr_sequencer (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .close_page(close_page), .t_rp(t_rp), .t_rcd(t_rcd), .t_cc(t_cc), .t_wrp(t_wrp),
        .t_ras(t_ras), .t_cwd(t_cwd), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .wdata_launch(wdata_launch)
    );

    typedef struct {
        int op; int bank; int row; int col; int at; string tag;
    } exp_t;

    exp_t exp_q[$];
    int   launch_q[$];
    int   errors = 0;
    int   checks = 0;
    int   cyc = 0;
    bit   done = 1'b0;

    // reference model state
    int p_rp, p_rcd, p_cc, p_wrp, p_ras, p_cwd;
    int m_last_pre = -1000, m_last_act = -1000, m_last_wr = -1000;
    int m_act_b[BANKS], m_wr_b[BANKS], m_row[BANKS];
    bit m_open[BANKS];
    int idle_from = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic push(int op, int b, int r, int c, int at, string tag);
        exp_t e;
        e.op = op; e.bank = b; e.row = r; e.col = c; e.at = at; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic set_timing(int rp, int rcd, int cc, int wrp, int ras, int cwd);
        repeat (80) @(negedge clk);
        p_rp = rp; p_rcd = rcd; p_cc = cc; p_wrp = wrp; p_ras = ras; p_cwd = cwd;
        t_rp = TW'(rp); t_rcd = TW'(rcd); t_cc = TW'(cc);
        t_wrp = TW'(wrp); t_ras = TW'(ras); t_cwd = TW'(cwd);
        repeat (2) @(negedge clk);
    endtask

    // Driver: presents one request and predicts every command it causes.
    task automatic send(int b, int r, int c, int len, bit cls);
        int start, a, t, x, col, last;
        bit hit;
        string wtag;
        @(negedge clk);
        req_bank = BA_W'(b); req_row = ROW_W'(r); req_col = COL_W'(c);
        req_len = LEN_W'(len); close_page = cls; req_valid = 1'b1;
        start = cyc;
        while (!req_ready) @(negedge clk);
        check(cyc == mx(start, idle_from), "R9", "accept cycle", cyc, mx(start, idle_from));
        a = cyc + 1;
        t = a + 1;
        hit = m_open[b] && (m_row[b] == r);
        if (m_open[b] && !hit) begin
            x = mx(mx(t, m_act_b[b] + p_ras), m_wr_b[b] + p_wrp);
            push(1, b, 0, 0, x, "R3 miss precharge");
            m_last_pre = x; m_open[b] = 1'b0; t = x + 1;
        end
        if (!hit) begin
            x = mx(t, m_last_pre + p_rp);
            push(2, b, r, 0, x, "R4 activate");
            m_last_act = x; m_act_b[b] = x; m_open[b] = 1'b1; m_row[b] = r; t = x + 1;
        end
        col = c;
        wtag = hit ? "R2 hit write" : "R5 write";
        for (int i = 0; i <= len; i++) begin
            x = mx(mx(t, m_last_act + p_rcd), m_last_wr + p_cc);
            push(3, b, 0, col, x, wtag);
            launch_q.push_back(x + p_cwd);
            m_last_wr = x; m_wr_b[b] = x; t = x + 1;
            col = (col + 1) % (1 << COL_W);
        end
        last = t - 1;
        if (cls) begin
            x = mx(mx(t, m_act_b[b] + p_ras), m_wr_b[b] + p_wrp);
            push(1, b, 0, 0, x, "R7 closing precharge");
            m_last_pre = x; m_open[b] = 1'b0; last = x;
        end
        idle_from = last;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare each command and strobe against the predicted queue.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (cmd_op != 2'd0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected command op", int'(cmd_op), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(int'(cmd_op) == e.op, e.tag, "op", int'(cmd_op), e.op);
                    check(cyc == e.at, e.tag, "cycle R10", cyc, e.at);
                    check(int'(cmd_bank) == e.bank, e.tag, "bank", int'(cmd_bank), e.bank);
                    check(int'(cmd_row) == e.row, "R8", "row field", int'(cmd_row), e.row);
                    check(int'(cmd_col) == e.col, e.tag, "col", int'(cmd_col), e.col);
                end
            end
            if (wdata_launch) begin
                if (launch_q.size() == 0) check(1'b0, "R6", "unexpected launch", cyc, -1);
                else begin
                    int w;
                    w = launch_q.pop_front();
                    check(cyc == w, "R6", "launch cycle", cyc, w);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "R10", "watchdog expired", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < BANKS; b++) begin
            m_act_b[b] = -1000; m_wr_b[b] = -1000; m_row[b] = 0; m_open[b] = 1'b0;
        end
        p_rp = 3; p_rcd = 2; p_cc = 2; p_wrp = 4; p_ras = 9; p_cwd = 3;
        t_rp = 6'd3; t_rcd = 6'd2; t_cc = 6'd2; t_wrp = 6'd4; t_ras = 6'd9; t_cwd = 6'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cmd_op == 2'd0, "R1", "cmd after reset", int'(cmd_op), 0);
        check(req_ready == 1'b1, "R1", "ready after reset", int'(req_ready), 1);
        check(wdata_launch == 1'b0, "R1", "launch after reset", int'(wdata_launch), 0);
        idle_from = cyc;

        // R1/R4 empty bank, R5 burst of three, R7 open policy
        send(0, 5, 0, 2, 1'b0);
        // R2 hit on the same row
        send(0, 5, 8, 0, 1'b0);
        // R3 miss, R7 close after the burst
        send(0, 7, 126, 1, 1'b1);
        // R7 bank left closed: empty again
        send(0, 7, 3, 0, 1'b0);
        send(3, 1, 10, 3, 1'b0);
        send(5, 2, 20, 0, 1'b0);
        send(3, 1, 30, 0, 1'b0);
        send(5, 9, 40, 2, 1'b1);

        // tighter write spacing, immediate launch, tRAS not the binding limit
        set_timing(2, 3, 1, 5, 2, 0);
        send(1, 4, 0, 4, 1'b1);
        send(1, 4, 5, 0, 1'b0);
        send(1, 6, 7, 0, 1'b1);

        set_timing(4, 1, 3, 1, 12, 7);
        for (int i = 0; i < 40; i++) begin
            send(int'($urandom % BANKS), int'($urandom % 3), int'($urandom % 128),
                 int'($urandom % 4), 1'($urandom % 2));
        end

        repeat (120) @(negedge clk);
        done = 1'b1;
        check(exp_q.size() == 0, "R8", "commands missing", exp_q.size(), 0);
        check(launch_q.size() == 0, "R6", "launches missing", launch_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule